// File: doc/BRIEF.md
# Way-Predicted Two-Way Read Cache

This block is a small read-only cache. It has two ways per set and one prediction bit per set. The prediction bit names the way that is expected to hit.

On the cycle a request is accepted, the block checks one tag only: the tag of the predicted way. The output data multiplexer is steered by the prediction before that check resolves. A correct guess answers in one cycle. A wrong guess costs two more cycles, in which the other way of the set is checked. If the other way hits, the prediction bit turns to it. If neither way holds the address, the block asks a lower-level memory for the word over a request/valid fill port. It stores the word in the way that was not predicted, which is the least recently used way of the set, and forwards the word to the requester.

Each line holds a single word. There are no writes. Three counters record how many accesses ended as predicted hits, slow hits and misses.

Top module: `wp_cache`

## Requirements
- R1: When an accepted address hits in the way named by its set's prediction bit, `rsp_valid_o` is high with the cached word in the cycle after acceptance, and the prediction bit is unchanged.
- R2: When the predicted way misses but the other way of the set holds the address, the response comes 3 cycles after acceptance, and the set's prediction bit then names the way that hit.
- R3: When both ways miss, `fill_req_o` rises 2 cycles after acceptance with `fill_addr_o` equal to the request address. Both stay steady until a cycle with `fill_valid_i` high. The response follows one cycle later and carries `fill_data_i` from that cycle.
- R4: A refill writes the way opposite the set's prediction bit (the least recently used way) and makes that way predicted. The line in the other way stays resident.
- R5: `req_ready_o` is high only when no access is in progress, so at most one request is outstanding. A new request may be accepted in the same cycle as a response.
- R6: `cnt_fast_o`, `cnt_slow_o` and `cnt_miss_o` each rise by one in the cycle whose response ends an access of that class. No counter moves in any other cycle.
- R7: After reset, every line is invalid, every prediction bit names way 0, all counters read zero, `req_ready_o` is high, and `rsp_valid_o` and `fill_req_o` are low.
- R8: Each accepted request produces exactly one `rsp_valid_o` cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request present |
| req_ready_o | output | 1 | Block can accept a request |
| req_addr_i | input | ADDR_W | Word address; low IDX_W bits select the set |
| rsp_valid_o | output | 1 | Read data valid, one cycle per request |
| rsp_data_o | output | DATA_W | Read data |
| fill_req_o | output | 1 | Line fetch request to lower memory |
| fill_addr_o | output | ADDR_W | Address of the line being fetched |
| fill_valid_i | input | 1 | Lower memory returns the line |
| fill_data_i | input | DATA_W | Returned line word |
| cnt_fast_o | output | CNT_W | Count of predicted-way hits |
| cnt_slow_o | output | CNT_W | Count of other-way hits |
| cnt_miss_o | output | CNT_W | Count of misses |

## Verification
The bench builds the block with an 8-bit address, 2 index bits (four sets), 32-bit data and 16-bit counters. With four sets, sixteen random addresses are enough to make sets fill, evict and alternate between ways often. That drives all three latency classes, prediction flips in both directions, and the rule that a refill evicts only the least recently used way. The fill responder answers after a fixed two-cycle wait, which makes the miss latency exact and puts the held fill request in view. A reset in the middle of a run shows that lines cached before it are gone afterwards.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  localparam int unsigned WAYS = 2;
  typedef enum logic [1:0] {ST_IDLE, ST_ALT, ST_ALT_W, ST_FILL} st_e;
endpackage

// File: rtl/wpc_store.sv
module wpc_store #(
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned TAG_W  = 6,
  parameter int unsigned DATA_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [IDX_W-1:0]       rd_idx_i,
  output logic [1:0]             rd_valid_o,
  output logic [1:0][TAG_W-1:0]  rd_tag_o,
  output logic [1:0][DATA_W-1:0] rd_data_o,
  output logic                   rd_pred_o,
  input  logic [IDX_W-1:0]       wr_idx_i,
  input  logic                   line_we_i,
  input  logic                   line_way_i,
  input  logic [TAG_W-1:0]       line_tag_i,
  input  logic [DATA_W-1:0]      line_data_i,
  input  logic                   pred_we_i,
  input  logic                   pred_way_i
);
  localparam int unsigned SETS = 1 << IDX_W;

  // one bit per set; also serves as the MRU marker
  logic [SETS-1:0] pred_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pred_q <= '0;
    else if (pred_we_i) pred_q[wr_idx_i] <= pred_way_i;
  end

  assign rd_pred_o = pred_q[rd_idx_i];

  for (genvar w = 0; w < wpc_pkg::WAYS; w++) begin : g_way
    logic [SETS-1:0]   vld_q;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];
    logic              wr_here;

    assign wr_here = line_we_i && (line_way_i == 1'(w));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) vld_q <= '0;
      else if (wr_here) vld_q[wr_idx_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (wr_here) begin
        tag_q[wr_idx_i]  <= line_tag_i;
        data_q[wr_idx_i] <= line_data_i;
      end
    end

    assign rd_valid_o[w] = vld_q[rd_idx_i];
    assign rd_tag_o[w]   = tag_q[rd_idx_i];
    assign rd_data_o[w]  = data_q[rd_idx_i];

    // a written line is valid when read back at that index
    assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_here |=> vld_q[$past(wr_idx_i)])
      else $error("assert_fill_valid_R4");
  end
endmodule

// File: rtl/wpc_ctrl.sv
module wpc_ctrl #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned TAG_W = ADDR_W - IDX_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_valid_i,
  input  logic [ADDR_W-1:0]      req_addr_i,
  output logic                   req_ready_o,
  output logic [IDX_W-1:0]       rd_idx_o,
  input  logic [1:0]             rd_valid_i,
  input  logic [1:0][TAG_W-1:0]  rd_tag_i,
  input  logic [1:0][DATA_W-1:0] rd_data_i,
  input  logic                   rd_pred_i,
  output logic [IDX_W-1:0]       wr_idx_o,
  output logic                   line_we_o,
  output logic                   line_way_o,
  output logic [TAG_W-1:0]       line_tag_o,
  output logic [DATA_W-1:0]      line_data_o,
  output logic                   pred_we_o,
  output logic                   pred_way_o,
  output logic                   fill_req_o,
  output logic [ADDR_W-1:0]      fill_addr_o,
  input  logic                   fill_valid_i,
  input  logic [DATA_W-1:0]      fill_data_i,
  output logic                   rsp_valid_o,
  output logic [DATA_W-1:0]      rsp_data_o,
  output logic                   ev_fast_o,
  output logic                   ev_slow_o,
  output logic                   ev_miss_o
);
  import wpc_pkg::*;

  st_e               state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              way_q;
  logic              rsp_valid_q;
  logic [DATA_W-1:0] rsp_data_q;

  logic              idle, accept, cmp_way, probe_hit;
  logic [ADDR_W-1:0] cur_addr;

  assign idle     = (state_q == ST_IDLE);
  assign accept   = idle && req_valid_i;
  assign cur_addr = idle ? req_addr_i : addr_q;
  assign rd_idx_o = cur_addr[IDX_W-1:0];

  // single comparator: predicted way first, the other way on the retry
  assign cmp_way   = idle ? rd_pred_i : ~way_q;
  assign probe_hit = rd_valid_i[cmp_way] &&
                     (rd_tag_i[cmp_way] == cur_addr[ADDR_W-1:IDX_W]);

  assign wr_idx_o    = addr_q[IDX_W-1:0];
  assign line_we_o   = (state_q == ST_FILL) && fill_valid_i;
  assign line_way_o  = ~way_q;
  assign line_tag_o  = addr_q[ADDR_W-1:IDX_W];
  assign line_data_o = fill_data_i;
  assign pred_we_o   = ((state_q == ST_ALT) && probe_hit) || line_we_o;
  assign pred_way_o  = ~way_q;

  assign fill_req_o  = (state_q == ST_FILL);
  assign fill_addr_o = addr_q;
  assign req_ready_o = idle;
  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  assign ev_fast_o = accept && probe_hit;
  assign ev_slow_o = (state_q == ST_ALT_W);
  assign ev_miss_o = line_we_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      way_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (accept) begin
          addr_q <= req_addr_i;
          way_q  <= rd_pred_i;
          if (probe_hit) begin
            rsp_valid_q <= 1'b1;
            rsp_data_q  <= rd_data_i[cmp_way];
          end else begin
            state_q <= ST_ALT;
          end
        end
        ST_ALT: begin
          if (probe_hit) begin
            rsp_data_q <= rd_data_i[cmp_way];
            state_q    <= ST_ALT_W;
          end else begin
            state_q <= ST_FILL;
          end
        end
        ST_ALT_W: begin
          rsp_valid_q <= 1'b1;
          state_q     <= ST_IDLE;
        end
        ST_FILL: if (fill_valid_i) begin
          rsp_valid_q <= 1'b1;
          rsp_data_q  <= fill_data_i;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && probe_hit) |=> rsp_valid_o)
    else $error("assert_fast_hit_R1");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ALT_W) |=> (rsp_valid_o && req_ready_o))
    else $error("assert_slow_hit_R2");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && !fill_valid_i) |=> (fill_req_o && $stable(fill_addr_o)))
    else $error("assert_fill_hold_R3");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && fill_valid_i) |=> (rsp_valid_o && (rsp_data_o == $past(fill_data_i))))
    else $error("assert_fill_forward_R3");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !probe_hit) |=> (!req_ready_o && !rsp_valid_o))
    else $error("assert_busy_R5");
endmodule

// File: rtl/wpc_perf.sv
module wpc_perf #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ev_fast_i,
  input  logic             ev_slow_i,
  input  logic             ev_miss_i,
  output logic [CNT_W-1:0] cnt_fast_o,
  output logic [CNT_W-1:0] cnt_slow_o,
  output logic [CNT_W-1:0] cnt_miss_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_fast_o <= '0;
      cnt_slow_o <= '0;
      cnt_miss_o <= '0;
    end else begin
      if (ev_fast_i) cnt_fast_o <= cnt_fast_o + 1'b1;
      if (ev_slow_i) cnt_slow_o <= cnt_slow_o + 1'b1;
      if (ev_miss_i) cnt_miss_o <= cnt_miss_o + 1'b1;
    end
  end

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({ev_fast_i, ev_slow_i, ev_miss_i}) <= 1)
    else $error("assert_one_class_R6");
endmodule

// File: rtl/wp_cache.sv
module wp_cache #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned IDX_W  = 2,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic              fill_req_o,
  output logic [ADDR_W-1:0] fill_addr_o,
  input  logic              fill_valid_i,
  input  logic [DATA_W-1:0] fill_data_i,
  output logic [CNT_W-1:0]  cnt_fast_o,
  output logic [CNT_W-1:0]  cnt_slow_o,
  output logic [CNT_W-1:0]  cnt_miss_o
);
  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]       rd_idx, wr_idx;
  logic [1:0]             rd_valid;
  logic [1:0][TAG_W-1:0]  rd_tag;
  logic [1:0][DATA_W-1:0] rd_data;
  logic                   rd_pred;
  logic                   line_we, line_way, pred_we, pred_way;
  logic [TAG_W-1:0]       line_tag;
  logic [DATA_W-1:0]      line_data;
  logic                   ev_fast, ev_slow, ev_miss;

  wpc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk_i, .rst_ni,
    .rd_idx_i(rd_idx), .rd_valid_o(rd_valid), .rd_tag_o(rd_tag),
    .rd_data_o(rd_data), .rd_pred_o(rd_pred),
    .wr_idx_i(wr_idx), .line_we_i(line_we), .line_way_i(line_way),
    .line_tag_i(line_tag), .line_data_i(line_data),
    .pred_we_i(pred_we), .pred_way_i(pred_way)
  );

  wpc_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_ctrl (
    .clk_i, .rst_ni,
    .req_valid_i, .req_addr_i, .req_ready_o,
    .rd_idx_o(rd_idx), .rd_valid_i(rd_valid), .rd_tag_i(rd_tag),
    .rd_data_i(rd_data), .rd_pred_i(rd_pred),
    .wr_idx_o(wr_idx), .line_we_o(line_we), .line_way_o(line_way),
    .line_tag_o(line_tag), .line_data_o(line_data),
    .pred_we_o(pred_we), .pred_way_o(pred_way),
    .fill_req_o, .fill_addr_o, .fill_valid_i, .fill_data_i,
    .rsp_valid_o, .rsp_data_o,
    .ev_fast_o(ev_fast), .ev_slow_o(ev_slow), .ev_miss_o(ev_miss)
  );

  wpc_perf #(.CNT_W(CNT_W)) u_perf (
    .clk_i, .rst_ni,
    .ev_fast_i(ev_fast), .ev_slow_i(ev_slow), .ev_miss_i(ev_miss),
    .cnt_fast_o, .cnt_slow_o, .cnt_miss_o
  );

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_fast_o != $past(cnt_fast_o)) |-> rsp_valid_o)
    else $error("assert_fast_count_R6");

  assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_miss_o != $past(cnt_miss_o)) |-> (rsp_valid_o && req_ready_o))
    else $error("assert_miss_count_R6");
endmodule

// File: tb/wp_cache_tb_top.sv
module wp_cache_tb_top;
  localparam int ADDR_W   = 8;
  localparam int IDX_W    = 2;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 16;
  localparam int SETS     = 1 << IDX_W;
  localparam int FILL_DLY = 2;
  localparam int MISS_LAT = 3 + FILL_DLY;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_valid_i = 1'b0;
  logic              req_ready_o;
  logic [ADDR_W-1:0] req_addr_i = '0;
  logic              rsp_valid_o;
  logic [DATA_W-1:0] rsp_data_o;
  logic              fill_req_o;
  logic [ADDR_W-1:0] fill_addr_o;
  logic              fill_valid_i = 1'b0;
  logic [DATA_W-1:0] fill_data_i = '0;
  logic [CNT_W-1:0]  cnt_fast_o, cnt_slow_o, cnt_miss_o;

  always #2 clk = ~clk;

  wp_cache #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk_i(clk), .rst_ni, .req_valid_i, .req_ready_o, .req_addr_i,
    .rsp_valid_o, .rsp_data_o, .fill_req_o, .fill_addr_o,
    .fill_valid_i, .fill_data_i, .cnt_fast_o, .cnt_slow_o, .cnt_miss_o
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural model state
  bit             m_vld  [SETS][2];
  int             m_tag  [SETS][2];
  logic [DATA_W-1:0] m_dat [SETS][2];
  bit             m_pred [SETS];
  int             m_fast, m_slow, m_miss;

  function automatic logic [DATA_W-1:0] mem_word(input logic [ADDR_W-1:0] a);
    return {a, ~a, a ^ 8'h5A, 8'hC3};
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int s = 0; s < SETS; s++) begin
      m_pred[s] = 1'b0;
      for (int w = 0; w < 2; w++) begin
        m_vld[s][w] = 1'b0;
        m_tag[s][w] = 0;
        m_dat[s][w] = '0;
      end
    end
    m_fast = 0; m_slow = 0; m_miss = 0;
  endtask

  // lower memory: answers FILL_DLY cycles after a request shows up
  int fwait = 0;
  always @(negedge clk) begin
    if (!rst_ni || !fill_req_o) begin
      fwait = 0;
      fill_valid_i = 1'b0;
    end else if (fwait == FILL_DLY) begin
      fill_valid_i = 1'b1;
      fill_data_i  = mem_word(fill_addr_o);
    end else begin
      fwait++;
      fill_valid_i = 1'b0;
    end
  end

  task automatic check_idle(input string req);
    chk(req_ready_o == 1'b1, req, req_ready_o, 1);
    chk(rsp_valid_o == 1'b0, req, rsp_valid_o, 0);
    chk(fill_req_o == 1'b0, req, fill_req_o, 0);
    chk(cnt_fast_o == 0 && cnt_slow_o == 0 && cnt_miss_o == 0, req,
        {cnt_fast_o, cnt_slow_o, cnt_miss_o}, 0);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    model_clear();
    check_idle("R7 in reset");
    rst_ni = 1'b1;
    @(negedge clk);
    check_idle("R7 after reset");
  endtask

  // called at a negedge with the block idle
  task automatic access(input logic [ADDR_W-1:0] a, input int exp_class);
    int s, t, p, o, lat, cls;
    logic [DATA_W-1:0] exp_d;
    string tag;
    s = int'(a[IDX_W-1:0]);
    t = int'(a[ADDR_W-1:IDX_W]);
    p = int'(m_pred[s]);
    o = 1 - p;
    if (m_vld[s][p] && m_tag[s][p] == t) begin
      cls = 0; lat = 1; exp_d = m_dat[s][p]; m_fast++; tag = "R1";
    end else if (m_vld[s][o] && m_tag[s][o] == t) begin
      cls = 1; lat = 3; exp_d = m_dat[s][o]; m_slow++; m_pred[s] = bit'(o); tag = "R2";
    end else begin
      cls = 2; lat = MISS_LAT; exp_d = mem_word(a); m_miss++;
      m_vld[s][o] = 1'b1; m_tag[s][o] = t; m_dat[s][o] = exp_d; m_pred[s] = bit'(o);
      tag = "R3";
    end
    if (exp_class >= 0) chk(cls == exp_class, "R4 scenario class", cls, exp_class);
    req_addr_i  = a;
    req_valid_i = 1'b1;
    @(negedge clk);
    req_valid_i = 1'b0;
    for (int k = 1; k <= lat; k++) begin
      chk(rsp_valid_o == (k == lat), {tag, " R8 response timing"}, rsp_valid_o, k == lat);
      chk(req_ready_o == (k == lat), "R5 ready", req_ready_o, k == lat);
      if (cls == 2 && k >= 2 && k < lat)
        chk(fill_req_o && fill_addr_o == a, "R3 fill request", fill_addr_o, a);
      if (k == lat) begin
        chk(rsp_data_o == exp_d, {tag, " data"}, rsp_data_o, exp_d);
        chk(cnt_fast_o == CNT_W'(m_fast), "R6 fast count", cnt_fast_o, m_fast);
        chk(cnt_slow_o == CNT_W'(m_slow), "R6 slow count", cnt_slow_o, m_slow);
        chk(cnt_miss_o == CNT_W'(m_miss), "R6 miss count", cnt_miss_o, m_miss);
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    model_clear();
    do_reset();
    // directed: set 1, tags 1,5,9
    access(8'h05, 2);   // R3 miss -> way1
    access(8'h05, 0);   // R1 fast
    access(8'h15, 2);   // R4 refill into way0, keeps 0x05
    access(8'h05, 1);   // R2 slow, prediction flips
    access(8'h05, 0);   // R1 after flip
    access(8'h15, 1);   // R2 slow again
    access(8'h25, 2);   // R4 evicts LRU 0x05
    access(8'h15, 1);   // R4 0x15 survived
    access(8'h05, 2);   // R4 0x05 was evicted
    access(8'h06, 2);   // other set unaffected
    access(8'h06, 0);
    // R7: state lost across reset
    do_reset();
    access(8'h06, 2);
    access(8'h06, 0);
    for (int i = 0; i < 600; i++)
      access(ADDR_W'($urandom_range(0, 15)), -1);
    repeat (2) @(negedge clk);
    chk(rsp_valid_o == 1'b0, "R8 no stray response", rsp_valid_o, 0);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=hang expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule